// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block controls the transmit side of a serial link's clock lane. It walks the lane from low-power idle through a fixed ladder of line states into continuous high-speed clocking, tells the data lanes when they may start, and walks the lane back to idle once the data lanes have finished. Each phase lasts a programmable number of cycles of the local timing clock. Analog drivers, serialization and the data lanes themselves are handled elsewhere.

A start request is a level. While it is high in idle, the lane steps through LP-01, LP-00, HS-0 and a pre-clocking interval. After that interval the lanes-ready flag is raised. The lane leaves clocking when two conditions hold together: the request is low and every data lane reports that it is back in low power. The lane then keeps clocking for the post interval, drives HS-0 for the trail interval, and holds LP-11 for the exit interval. Each phase loads its own down-counter when it is entered and ends on the cycle that counter reads zero. A phase programmed with value T therefore lasts T+1 cycles.

Top module: `clk_lane_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, line_state is LP-11 (code 0) and lanes_ready is 0.
- R2: The line codes are LP-11=0, LP-01=1, LP-00=2, HS-0=3, HS-clock=4. Entry always runs LP-11, LP-01, LP-00, HS-0, HS-clock, and HS-clock is entered only from HS-0.
- R3: After the first clock edge that sees hs_req high in idle, line_state is LP-01 for t_lpx+1 cycles.
- R4: LP-00 (clock prepare) then lasts t_prep+1 cycles.
- R5: HS-0 (clock zero) then lasts t_zero+1 cycles, after which HS-clock begins.
- R6: lanes_ready stays 0 for the first t_pre+1 HS-clock cycles. It is 1 from then until the exit condition is seen, and it is only ever 1 while line_state is HS-clock.
- R7: The exit condition is hs_req low together with data_lp_done high. Either one alone leaves the lane clocking with lanes_ready at 1.
- R8: After the exit condition, HS-clock continues for t_post+1 cycles with lanes_ready at 0.
- R9: HS-0 (clock trail) then lasts t_trail+1 cycles, and LP-11 follows directly.
- R10: LP-11 after a burst lasts t_exit+1 cycles whatever hs_req does. A request made during that time is held, and LP-01 appears in the first cycle after the exit interval.
- R11: Dropping hs_req during entry does not abort the entry. The lane still reaches HS-clock with lanes_ready at 1.
- R12: With hs_req low in idle, the lane stays in LP-11 with lanes_ready at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | Level request for high-speed clocking |
| data_lp_done | input | 1 | All data lanes are back in low power |
| t_lpx | input | CNT_W | LP-01 length minus one |
| t_prep | input | CNT_W | Clock prepare (LP-00) length minus one |
| t_zero | input | CNT_W | Clock zero (HS-0) length minus one |
| t_pre | input | CNT_W | Pre-clocking length minus one |
| t_post | input | CNT_W | Post-clocking length minus one |
| t_trail | input | CNT_W | Clock trail (HS-0) length minus one |
| t_exit | input | CNT_W | Exit LP-11 length minus one |
| line_state | output | 3 | Line-state code (see R2) |
| lanes_ready | output | 1 | Data lanes may begin HS entry |

## Verification
The end of the exit interval and a new start request can fall in the same cycle. The bench raises hs_req partway through the exit LP-11 hold. It then checks that LP-11 lasts exactly the programmed exit length and that LP-01 starts in the very next cycle, with no extra idle cycle in between. A second overlap is checked while clocking. The request can drop on the same edge that data_lp_done rises, or the two can move separately. The bench applies each half of the exit condition alone and expects lanes_ready to stay high. It then applies both together and expects the post interval to start on the following edge.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_REQ   = 4'd1,
    ST_PREP  = 4'd2,
    ST_ZERO  = 4'd3,
    ST_PRE   = 4'd4,
    ST_RUN   = 4'd5,
    ST_POST  = 4'd6,
    ST_TRAIL = 4'd7,
    ST_EXIT  = 4'd8
  } cl_state_e;

  localparam logic [2:0] LINE_LP11  = 3'd0;
  localparam logic [2:0] LINE_LP01  = 3'd1;
  localparam logic [2:0] LINE_LP00  = 3'd2;
  localparam logic [2:0] LINE_HS0   = 3'd3;
  localparam logic [2:0] LINE_HSCLK = 3'd4;

  function automatic logic [2:0] line_of(cl_state_e st);
    case (st)
      ST_REQ:                  line_of = LINE_LP01;
      ST_PREP:                 line_of = LINE_LP00;
      ST_ZERO, ST_TRAIL:       line_of = LINE_HS0;
      ST_PRE, ST_RUN, ST_POST: line_of = LINE_HSCLK;
      default:                 line_of = LINE_LP11;
    endcase
  endfunction

endpackage

// File: rtl/clk_lane_tmr.sv
module clk_lane_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
  import clk_lane_pkg::*;
(
  input  cl_state_e state_q,
  input  logic      hs_req,
  input  logic      data_lp_done,
  input  logic      expired,
  output cl_state_e state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (hs_req) state_d = ST_REQ;
      ST_REQ:   if (expired) state_d = ST_PREP;
      ST_PREP:  if (expired) state_d = ST_ZERO;
      ST_ZERO:  if (expired) state_d = ST_PRE;
      ST_PRE:   if (expired) state_d = ST_RUN;
      ST_RUN:   if (!hs_req && data_lp_done) state_d = ST_POST;
      ST_POST:  if (expired) state_d = ST_TRAIL;
      ST_TRAIL: if (expired) state_d = ST_EXIT;
      ST_EXIT:  if (expired) state_d = hs_req ? ST_REQ : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_req,
  input  logic             data_lp_done,
  input  logic [CNT_W-1:0] t_lpx,
  input  logic [CNT_W-1:0] t_prep,
  input  logic [CNT_W-1:0] t_zero,
  input  logic [CNT_W-1:0] t_pre,
  input  logic [CNT_W-1:0] t_post,
  input  logic [CNT_W-1:0] t_trail,
  input  logic [CNT_W-1:0] t_exit,
  output logic [2:0]       line_state,
  output logic             lanes_ready
);
  cl_state_e        state_q;
  cl_state_e        state_d;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  clk_lane_fsm u_fsm (
    .state_q      (state_q),
    .hs_req       (hs_req),
    .data_lp_done (data_lp_done),
    .expired      (expired),
    .state_d      (state_d)
  );

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_REQ:   tmr_val = t_lpx;
      ST_PREP:  tmr_val = t_prep;
      ST_ZERO:  tmr_val = t_zero;
      ST_PRE:   tmr_val = t_pre;
      ST_POST:  tmr_val = t_post;
      ST_TRAIL: tmr_val = t_trail;
      ST_EXIT:  tmr_val = t_exit;
      default:  tmr_val = '0;
    endcase
  end

  clk_lane_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_IDLE;
    else if (tmr_load) state_q <= state_d;
  end

  assign line_state  = line_of(state_q);
  assign lanes_ready = (state_q == ST_RUN);
endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_req,
  input logic       data_lp_done,
  input logic [2:0] line_state,
  input logic       lanes_ready
);
  a_r6_ready_only_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_ready |-> line_state == 3'd4);

  a_r2_lp01_from_lp11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd1 && $past(line_state) != 3'd1) |-> $past(line_state) == 3'd0);

  a_r2_lp00_from_lp01: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd2 && $past(line_state) != 3'd2) |-> $past(line_state) == 3'd1);

  a_r2_hsclk_from_hs0: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd4 && $past(line_state) != 3'd4) |-> $past(line_state) == 3'd3);

  a_r9_lp11_after_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 3'd0 && $past(line_state) != 3'd0) |-> $past(line_state) == 3'd3);

  a_r6_ready_rise_in_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lanes_ready) |-> $past(line_state) == 3'd4);

  a_r7_ready_fall_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lanes_ready) |-> $past(!hs_req && data_lp_done));
endmodule

bind clk_lane_seq clk_lane_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hs_req       (hs_req),
  .data_lp_done (data_lp_done),
  .line_state   (line_state),
  .lanes_ready  (lanes_ready)
);

// File: tb/tb_clk_lane_seq.sv
module tb_clk_lane_seq;
  localparam int CNT_W = 8;
  localparam int NV = 5;
  // lpx, prep, zero, pre, post, trail, exit
  localparam int VEC [0:NV-1][0:6] = '{
    '{2, 3, 4, 5, 3, 2, 4},
    '{0, 0, 0, 0, 0, 0, 0},
    '{4, 1, 6, 2, 7, 3, 1},
    '{1, 5, 2, 8, 2, 5, 6},
    '{3, 2, 1, 1, 10, 1, 9}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic hs_req, data_lp_done;
  logic [CNT_W-1:0] t_lpx, t_prep, t_zero, t_pre, t_post, t_trail, t_exit;
  logic [2:0] line_state;
  logic lanes_ready;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_lane_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .data_lp_done(data_lp_done),
    .t_lpx(t_lpx), .t_prep(t_prep), .t_zero(t_zero), .t_pre(t_pre),
    .t_post(t_post), .t_trail(t_trail), .t_exit(t_exit),
    .line_state(line_state), .lanes_ready(lanes_ready)
  );

  task automatic check_now(input logic [2:0] code, input logic rdy, input string tag);
    n_chk++;
    if (line_state !== code || lanes_ready !== rdy) begin
      n_bad++;
      $display("FAIL %s: line=%0d ready=%0b expected line=%0d ready=%0b",
               tag, line_state, lanes_ready, code, rdy);
    end
  endtask

  task automatic expect_phase(input logic [2:0] code, input logic rdy,
                              input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_now(code, rdy, tag);
    end
  endtask

  task automatic load_vec(input int v);
    t_lpx = VEC[v][0]; t_prep = VEC[v][1]; t_zero = VEC[v][2]; t_pre = VEC[v][3];
    t_post = VEC[v][4]; t_trail = VEC[v][5]; t_exit = VEC[v][6];
  endtask

  task automatic do_reset;
    rst_n = 1'b0; hs_req = 1'b0; data_lp_done = 1'b0;
    @(negedge clk);
    check_now(3'd0, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(3'd0, 1'b0, "R1 after reset");
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    load_vec(0);
    do_reset();
    // R12 idle without request
    expect_phase(3'd0, 1'b0, 4, "R12 idle");

    for (int v = 0; v < NV; v++) begin
      load_vec(v);
      hs_req = 1'b1;
      expect_phase(3'd1, 1'b0, VEC[v][0] + 1, "R3 LP-01");
      expect_phase(3'd2, 1'b0, VEC[v][1] + 1, "R4 LP-00");
      expect_phase(3'd3, 1'b0, VEC[v][2] + 1, "R5 HS-0 zero");
      expect_phase(3'd4, 1'b0, VEC[v][3] + 1, "R6 pre");
      expect_phase(3'd4, 1'b1, 4, "R6 ready");
      hs_req = 1'b0; data_lp_done = 1'b1;
      expect_phase(3'd4, 1'b0, VEC[v][4] + 1, "R8 post");
      expect_phase(3'd3, 1'b0, VEC[v][5] + 1, "R9 trail");
      data_lp_done = 1'b0;
      expect_phase(3'd0, 1'b0, VEC[v][6] + 1, "R10 exit");
      expect_phase(3'd0, 1'b0, 2, "R12 idle after burst");
    end

    // Directed: drop request mid-entry, half exit conditions, request during exit
    load_vec(0);
    hs_req = 1'b1;
    expect_phase(3'd1, 1'b0, VEC[0][0] + 1, "R3 LP-01");
    hs_req = 1'b0;
    expect_phase(3'd2, 1'b0, VEC[0][1] + 1, "R11 LP-00 after drop");
    expect_phase(3'd3, 1'b0, VEC[0][2] + 1, "R11 HS-0 after drop");
    expect_phase(3'd4, 1'b0, VEC[0][3] + 1, "R11 pre after drop");
    expect_phase(3'd4, 1'b1, 3, "R11 ready after drop");
    // request low, data lanes not done
    expect_phase(3'd4, 1'b1, 3, "R7 only request low");
    hs_req = 1'b1; data_lp_done = 1'b1;
    expect_phase(3'd4, 1'b1, 3, "R7 only data done");
    hs_req = 1'b0;
    expect_phase(3'd4, 1'b0, VEC[0][4] + 1, "R8 post");
    data_lp_done = 1'b0;
    expect_phase(3'd3, 1'b0, VEC[0][5] + 1, "R9 trail");
    expect_phase(3'd0, 1'b0, 2, "R10 exit start");
    hs_req = 1'b1;
    expect_phase(3'd0, 1'b0, VEC[0][6] - 1, "R10 exit held");
    expect_phase(3'd1, 1'b0, VEC[0][0] + 1, "R10 LP-01 right after exit");
    expect_phase(3'd2, 1'b0, 1, "R2 LP-00 follows LP-01");

    // Reset in the middle of entry
    do_reset();
    expect_phase(3'd0, 1'b0, 2, "R12 idle after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule